// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Sequencer

This block loads a bitstream into a target FPGA over a byte-wide slave parallel configuration port. A one-cycle start pulse, together with a byte count, launches one load. The sequencer pulls the target's active-low program pin low and holds it there for a minimum time. It then watches the target's init pin go low and come back high. Next it selects the port for writing and clocks the bytes across, one per configuration clock cycle. The bytes come from a valid/ready stream. The configuration clock is the system clock divided down.

During the load, a low init pin counts as a configuration error. A done pin that rises before the last byte cuts the transfer short. When the BUSY check is compiled in, a high busy pin holds back the next byte. After the transfer, the block waits for done high and init high. Every wait has its own timeout, counted in system clock cycles. The result is either a sticky success flag or a sticky error code, plus the byte offset of a load error. After any abort the target pins are parked and the block returns to idle.

Top module: `cfg_loader_top`

## Requirements
- R1: After reset, and whenever idle, `prog_n_o`, `cs_n_o`, `rdwr_n_o` and `cclk_o` are high, `active_o` and `ok_o` are low and `err_code_o` is 0.
- R2: A load begins with `prog_n_o` low for at least PROG_CYC cycles, and it stays low until `init_n_i` has been seen low. If `init_n_i` is not seen low within INIT_TO cycles, the load aborts with code 1.
- R3: After `prog_n_o` is released, no select or data activity happens until `init_n_i` is high. If `init_n_i` stays low for INIT_TO cycles, the load aborts with code 1.
- R4: `cs_n_o` and `rdwr_n_o` are low together for the whole transfer and high afterwards. Each byte is sent as one `cclk_o` low phase followed by one high phase, each CLK_DIV cycles long. `cfg_data_o` is stable at the rising edge, and bytes leave in stream order.
- R5: `s_ready_o` is high only in a cycle where `s_valid_i` is high and a byte is taken. No more than `byte_count_i` bytes are consumed.
- R6: If `init_n_i` is low between bytes during the transfer, the load aborts with code 2. `err_offset_o` then holds the number of bytes already clocked out.
- R7: If `done_i` is high between bytes, no further byte is sent and the block goes straight to the final check.
- R8: With the BUSY check enabled, no byte is taken while `busy_i` is high. If `busy_i` stays high for BUSY_TO cycles, the load aborts with code 3.
- R9: After the transfer, `ok_o` rises once `done_i` and `init_n_i` are both high. If that does not happen within DONE_TO cycles, the load aborts with code 4.
- R10: An abort parks all target pins high and returns the block to idle. `ok_o` and a nonzero `err_code_o` are never both set.
- R11: `start_i` has no effect while a load is active. A start in idle clears `ok_o` and `err_code_o` by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for one load |
| byte_count_i | input | CNT_W | Number of bytes to send, sampled at start |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | DATA_W | Stream byte |
| s_ready_o | output | 1 | Stream byte taken this cycle |
| init_n_i | input | 1 | Target init pin (active low) |
| busy_i | input | 1 | Target busy pin |
| done_i | input | 1 | Target done pin |
| prog_n_o | output | 1 | Target program pin (active low) |
| cs_n_o | output | 1 | Target chip select (active low) |
| rdwr_n_o | output | 1 | Target write enable (low = write) |
| cclk_o | output | 1 | Configuration clock |
| cfg_data_o | output | DATA_W | Configuration data bus |
| active_o | output | 1 | A load is in progress |
| ok_o | output | 1 | Sticky success flag |
| err_code_o | output | 3 | Sticky error code: 0 none, 1 init timeout, 2 load error, 3 busy timeout, 4 done timeout |
| err_offset_o | output | CNT_W | Bytes sent when a load error was seen |

## Verification
The assertions take the target pins to be already synchronous to `clk`. They also assume that `start_i` and the stream inputs change only between edges, so any value seen at an edge is a settled one. No stability rule is assumed on `s_valid_i`. The bench drives every input at the falling clock edge, and a behavioural target model sets init, busy and done in response to the bytes it has captured. A stream byte is held until it has been taken, and the offered stream always runs three bytes past the programmed count.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_INIT_HI, ST_FETCH, ST_CLK_LO, ST_CLK_HI, ST_CHECK
  } ld_state_e;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_INIT_TO = 3'd1,
    ERR_LOAD    = 3'd2,
    ERR_BUSY_TO = 3'd3,
    ERR_DONE_TO = 3'd4
  } ld_err_e;

  typedef struct packed {
    logic prog_n;
    logic cs_n;
    logic rdwr_n;
    logic cclk;
    logic active;
  } pin_t;

  // Target pin levels held in each state.
  function automatic pin_t pins_for(ld_state_e s);
    pin_t p;
    p = '{prog_n: 1'b1, cs_n: 1'b1, rdwr_n: 1'b1, cclk: 1'b1, active: 1'b1};
    case (s)
      ST_IDLE:  p.active = 1'b0;
      ST_PROG:  p.prog_n = 1'b0;
      ST_FETCH, ST_CLK_HI: begin
        p.cs_n   = 1'b0;
        p.rdwr_n = 1'b0;
      end
      ST_CLK_LO: begin
        p.cs_n   = 1'b0;
        p.rdwr_n = 1'b0;
        p.cclk   = 1'b0;
      end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/cfg_cycle_timer.sv
module cfg_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt_o
);
  // Saturating up-counter, restarted by clr.
  always_ff @(posedge clk) begin
    if (rst || clr)        cnt_o <= '0;
    else if (cnt_o != '1)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/cfg_busy_gate.sv
module cfg_busy_gate #(
  parameter bit ENABLE = 1'b1,
  parameter int W      = 8,
  parameter int LIMIT  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic watch_i,
  input  logic busy_i,
  output logic hold_o,
  output logic expire_o
);
  generate
    if (ENABLE) begin : g_on
      logic [W-1:0] busy_cnt;
      cfg_cycle_timer #(.W(W)) u_busy_tmr (
        .clk   (clk),
        .rst   (rst),
        .clr   (!(watch_i && busy_i)),
        .cnt_o (busy_cnt)
      );
      assign hold_o   = busy_i;
      assign expire_o = watch_i && busy_i && (busy_cnt == W'(LIMIT - 1));
    end else begin : g_off
      assign hold_o   = 1'b0;
      assign expire_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cfg_loader_top.sv
module cfg_loader_top
  import cfg_loader_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 16,
  parameter int PROG_CYC   = 30,
  parameter int INIT_TO    = 50_000_000,
  parameter int BUSY_TO    = 500_000,
  parameter int DONE_TO    = 20_000_000,
  parameter int CLK_DIV    = 1,
  parameter bit BUSY_CHECK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              s_ready_o,
  input  logic              init_n_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              prog_n_o,
  output logic              cs_n_o,
  output logic              rdwr_n_o,
  output logic              cclk_o,
  output logic [DATA_W-1:0] cfg_data_o,
  output logic              active_o,
  output logic              ok_o,
  output logic [2:0]        err_code_o,
  output logic [CNT_W-1:0]  err_offset_o
);

  localparam int MAX_A  = (INIT_TO > DONE_TO) ? INIT_TO : DONE_TO;
  localparam int MAX_B  = (BUSY_TO > PROG_CYC) ? BUSY_TO : PROG_CYC;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T  = (MAX_C > CLK_DIV) ? MAX_C : CLK_DIV;
  localparam int TMR_W  = $clog2(MAX_T + 1);
  localparam logic [TMR_W-1:0] PROG_LIM = TMR_W'(PROG_CYC - 1);
  localparam logic [TMR_W-1:0] INIT_LIM = TMR_W'(INIT_TO - 1);
  localparam logic [TMR_W-1:0] DONE_LIM = TMR_W'(DONE_TO - 1);
  localparam logic [TMR_W-1:0] DIV_LIM  = TMR_W'(CLK_DIV - 1);

  ld_state_e         state_q, state_d;
  ld_err_e           err_q, abort_code;
  pin_t              pins_q;
  logic [TMR_W-1:0]  tmr;
  logic [CNT_W-1:0]  sent_q, total_q, off_q;
  logic [DATA_W-1:0] data_q;
  logic              init_seen_q, ok_q, abort, succeed, accept;
  logic              busy_hold, busy_expire;

  // One timer serves every wait and both clock phases; it restarts on each state change.
  cfg_cycle_timer #(.W(TMR_W)) u_state_tmr (
    .clk   (clk),
    .rst   (rst),
    .clr   (state_d != state_q),
    .cnt_o (tmr)
  );

  cfg_busy_gate #(.ENABLE(BUSY_CHECK), .W(TMR_W), .LIMIT(BUSY_TO)) u_busy_gate (
    .clk      (clk),
    .rst      (rst),
    .watch_i  (state_q == ST_FETCH),
    .busy_i   (busy_i),
    .hold_o   (busy_hold),
    .expire_o (busy_expire)
  );

  assign accept = (state_q == ST_FETCH) && !done_i && init_n_i &&
                  (sent_q != total_q) && !busy_hold && s_valid_i;

  always_comb begin
    state_d    = state_q;
    abort      = 1'b0;
    abort_code = ERR_NONE;
    succeed    = 1'b0;
    case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_PROG;
      ST_PROG: begin
        if (tmr >= PROG_LIM && (init_seen_q || !init_n_i)) state_d = ST_INIT_HI;
        else if (tmr == INIT_LIM) begin abort = 1'b1; abort_code = ERR_INIT_TO; end
      end
      ST_INIT_HI: begin
        if (init_n_i)              state_d = ST_FETCH;
        else if (tmr == INIT_LIM) begin abort = 1'b1; abort_code = ERR_INIT_TO; end
      end
      ST_FETCH: begin
        if (done_i)                state_d = ST_CHECK;
        else if (!init_n_i) begin abort = 1'b1; abort_code = ERR_LOAD; end
        else if (sent_q == total_q) state_d = ST_CHECK;
        else if (busy_expire) begin abort = 1'b1; abort_code = ERR_BUSY_TO; end
        else if (accept)           state_d = ST_CLK_LO;
      end
      ST_CLK_LO:  if (tmr >= DIV_LIM) state_d = ST_CLK_HI;
      ST_CLK_HI:  if (tmr >= DIV_LIM) state_d = ST_FETCH;
      ST_CHECK: begin
        if (done_i && init_n_i) begin succeed = 1'b1; state_d = ST_IDLE; end
        else if (tmr == DONE_LIM) begin abort = 1'b1; abort_code = ERR_DONE_TO; end
      end
      default:    state_d = ST_IDLE;
    endcase
    if (abort) state_d = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pins_q      <= pins_for(ST_IDLE);
      err_q       <= ERR_NONE;
      ok_q        <= 1'b0;
      off_q       <= '0;
      sent_q      <= '0;
      total_q     <= '0;
      data_q      <= '0;
      init_seen_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pins_q  <= pins_for(state_d);
      if (state_q == ST_IDLE && start_i) begin
        err_q       <= ERR_NONE;
        ok_q        <= 1'b0;
        off_q       <= '0;
        total_q     <= byte_count_i;
        sent_q      <= '0;
        init_seen_q <= 1'b0;
      end
      if (state_q == ST_PROG && !init_n_i) init_seen_q <= 1'b1;
      if (accept) data_q <= s_data_i;
      if (state_q == ST_CLK_HI && state_d == ST_FETCH) sent_q <= sent_q + 1'b1;
      if (abort) begin
        err_q <= abort_code;
        if (abort_code == ERR_LOAD) off_q <= sent_q;
      end
      if (succeed) ok_q <= 1'b1;
    end
  end

  assign s_ready_o    = accept;
  assign prog_n_o     = pins_q.prog_n;
  assign cs_n_o       = pins_q.cs_n;
  assign rdwr_n_o     = pins_q.rdwr_n;
  assign cclk_o       = pins_q.cclk;
  assign active_o     = pins_q.active;
  assign cfg_data_o   = data_q;
  assign ok_o         = ok_q;
  assign err_code_o   = err_q;
  assign err_offset_o = off_q;

  // Checker support: length of the current program pulse.
  logic [TMR_W-1:0] prog_lo_cnt;
  always_ff @(posedge clk) begin
    if (rst)                      prog_lo_cnt <= '0;
    else if (!prog_n_o) begin
      if (prog_lo_cnt != '1)      prog_lo_cnt <= prog_lo_cnt + 1'b1;
    end else                      prog_lo_cnt <= '0;
  end

  AST_PROG_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_n_o) |-> prog_lo_cnt >= TMR_W'(PROG_CYC)); // R2
  AST_SELECT_AFTER_INIT: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> $past(init_n_i) && prog_n_o); // R3
  AST_DATA_STABLE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk_o) |-> $stable(cfg_data_o) && !cs_n_o); // R4
  AST_CCLK_LOW_SELECTED: assert property (@(posedge clk) disable iff (rst)
    !cclk_o |-> !cs_n_o && !rdwr_n_o); // R4
  AST_READY_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    s_ready_o |-> s_valid_i && !cs_n_o && cclk_o && !busy_i); // R5
  AST_ABORT_PARKS: assert property (@(posedge clk) disable iff (rst)
    $fell(active_o) |-> prog_n_o && cs_n_o && rdwr_n_o && cclk_o); // R10
  AST_OK_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(ok_o && err_code_o != 3'd0)); // R10
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(!active_o && !start_i) && !active_o |-> $stable(err_code_o) && $stable(ok_o)); // R11

endmodule

// File: tb/cfg_loader_top_tb_top.sv
module cfg_loader_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int PROG_CYC   = 4;
  localparam int INIT_TO    = 40;
  localparam int BUSY_TO    = 12;
  localparam int DONE_TO    = 30;
  localparam int CLK_DIV    = 2;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic init_n = 1'b1, busy = 1'b0, done = 1'b0;
  logic s_ready, prog_n, cs_n, rdwr_n, cclk, active, ok;
  logic [7:0] cfg_data;
  logic [2:0] err_code;
  logic [CNT_W-1:0] err_off;

  int n_chk = 0, n_fail = 0;
  int cap_cnt = 0, cap_base = 0, acc_cnt = 0;
  int lo_run = 0, prog_w = 0;
  logic [7:0] cap_mem [64];
  bit run_over = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_loader_top #(
    .DATA_W(8), .CNT_W(CNT_W), .PROG_CYC(PROG_CYC), .INIT_TO(INIT_TO),
    .BUSY_TO(BUSY_TO), .DONE_TO(DONE_TO), .CLK_DIV(CLK_DIV), .BUSY_CHECK(1'b1)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .byte_count_i(byte_count),
    .s_valid_i(s_valid), .s_data_i(s_data), .s_ready_o(s_ready),
    .init_n_i(init_n), .busy_i(busy), .done_i(done),
    .prog_n_o(prog_n), .cs_n_o(cs_n), .rdwr_n_o(rdwr_n), .cclk_o(cclk),
    .cfg_data_o(cfg_data), .active_o(active), .ok_o(ok),
    .err_code_o(err_code), .err_offset_o(err_off)
  );

  // Target model: capture each byte at the rising configuration clock.
  always @(posedge cclk) begin
    if (!cs_n) begin
      cap_mem[cap_cnt % 64] = cfg_data;
      cap_cnt = cap_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (!prog_n) lo_run = lo_run + 1;
    else if (lo_run > 0) begin prog_w = lo_run; lo_run = 0; end
  end

  function automatic logic [7:0] pat(int seed, int i);
    return 8'(i * 37 + seed * 11 + 5);
  endfunction

  task automatic chk(bit cond, string req, int act, int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic stream_send(int n_avail, int seed, int gap);
    acc_cnt = 0;
    for (int i = 0; i < n_avail && !run_over; i++) begin
      if (gap > 0 && (i % 2) == 1) repeat (gap) @(negedge clk);
      s_valid = 1'b1;
      s_data  = pat(seed, i);
      #1;
      while (!s_ready && !run_over) begin @(negedge clk); #1; end
      if (s_ready) acc_cnt++;
      @(negedge clk);
      s_valid = 1'b0;
    end
    s_valid = 1'b0;
    while (!run_over) @(negedge clk);
  endtask

  task automatic target_run(int lo_dly, int hi_dly, bit never_low, bit stuck_low,
                            int err_at, int done_at, int busy_len, bit busy_stuck);
    int last_cap, bcnt, got;
    init_n = 1'b1; done = 1'b0; busy = 1'b0;
    last_cap = 0; bcnt = 0;
    while (prog_n) @(negedge clk);
    repeat (lo_dly) @(negedge clk);
    if (!never_low) init_n = 1'b0;
    while (!prog_n && active) @(negedge clk);
    if (active) begin
      repeat (hi_dly) @(negedge clk);
      if (!stuck_low) init_n = 1'b1;
    end
    while (active) begin
      got = cap_cnt - cap_base;
      if (!cs_n && err_at >= 0 && got == err_at) init_n = 1'b0;
      if (!cs_n && done_at >= 0 && got == done_at) done = 1'b1;
      if (busy_stuck && got >= 1) busy = 1'b1;
      else if (busy_len > 0) begin
        if (got != last_cap) begin busy = 1'b1; bcnt = busy_len; last_cap = got; end
        else if (bcnt > 0) begin bcnt--; if (bcnt == 0) busy = 1'b0; end
      end
      @(negedge clk);
    end
    busy = 1'b0;
    run_over = 1'b1;
  endtask

  task automatic run_case(int n, int seed, int gap, int lo_dly, int hi_dly,
                          bit never_low, bit stuck_low, int err_at, int done_at,
                          int busy_len, bit busy_stuck, bit mid_start,
                          int exp_code, bit exp_ok, int exp_caps, int exp_off);
    int got, mism;
    cap_base = cap_cnt;
    run_over = 1'b0;
    @(negedge clk);
    byte_count = CNT_W'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err_code == 3'd0 && !ok && active, "R11", int'(err_code), 0);
    fork
      stream_send(n + 3, seed, gap);
      target_run(lo_dly, hi_dly, never_low, stuck_low, err_at, done_at, busy_len, busy_stuck);
      begin
        if (mid_start) begin
          repeat (30) @(negedge clk);
          byte_count = CNT_W'(n + 2);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join
    @(negedge clk);
    got = cap_cnt - cap_base;
    chk(int'(err_code) == exp_code, exp_code == 1 ? "R2" : exp_code == 2 ? "R6" :
        exp_code == 3 ? "R8" : exp_code == 4 ? "R9" : "R9", int'(err_code), exp_code);
    chk(ok == exp_ok, "R9", int'(ok), int'(exp_ok));
    chk(got == exp_caps, mid_start ? "R11" : done_at >= 0 && done_at < n ? "R7" : "R4",
        got, exp_caps);
    chk(acc_cnt == exp_caps, "R5", acc_cnt, exp_caps);
    mism = 0;
    for (int i = 0; i < exp_caps; i++)
      if (cap_mem[(cap_base + i) % 64] != pat(seed, i)) mism++;
    chk(mism == 0, "R4", mism, 0);
    if (exp_code == 2) chk(int'(err_off) == exp_off, "R6", int'(err_off), exp_off);
    chk(prog_n && cs_n && rdwr_n && cclk && !active, "R10",
        {prog_n, cs_n, rdwr_n, cclk, active}, 5'b11110);
    chk(prog_w >= PROG_CYC && (never_low || prog_w >= lo_dly + 1), "R2", prog_w, PROG_CYC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset levels
    chk(prog_n && cs_n && rdwr_n && cclk && !active && !ok && err_code == 3'd0,
        "R1", {prog_n, cs_n, rdwr_n, cclk, active, ok}, 6'b111100);
    // R4/R9: clean loads, sweep of lengths, init delays and stream gaps
    for (int n = 0; n <= 6; n++)
      run_case(n, n, (n % 2) * 2, (n % 3) * 3, (n % 2) * 2, 0, 0, -1, n, 0, 0, 0,
               0, 1, n, 0);
    // R2: init never goes low
    run_case(3, 7, 0, 0, 0, 1, 0, -1, 3, 0, 0, 0, 1, 0, 0, 0);
    // R3: init stays low after release
    run_case(3, 8, 0, 1, 0, 0, 1, -1, 3, 0, 0, 0, 1, 0, 0, 0);
    // R6: load error at several offsets
    for (int k = 0; k <= 3; k++)
      run_case(5, 10 + k, 0, 1, 1, 0, 0, k, -1, 0, 0, 0, 2, 0, k, k);
    // R7: early done
    for (int k = 1; k <= 3; k++)
      run_case(6, 20 + k, 1, 0, 0, 0, 0, -1, k, 0, 0, 0, 0, 1, k, 0);
    // R8: busy throttle, then busy stuck
    run_case(4, 30, 0, 0, 1, 0, 0, -1, 4, 5, 0, 0, 0, 1, 4, 0);
    run_case(4, 31, 0, 0, 1, 0, 0, -1, 4, 0, 1, 0, 3, 0, 1, 0);
    // R9: done never rises
    run_case(3, 40, 0, 0, 0, 0, 0, -1, -1, 0, 0, 0, 4, 0, 3, 0);
    run_case(0, 41, 0, 0, 0, 0, 0, -1, -1, 0, 0, 0, 4, 0, 0, 0);
    // R11: start during a load is ignored
    run_case(6, 50, 0, 0, 0, 0, 0, -1, 6, 0, 0, 1, 0, 1, 6, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule